// File: doc/BRIEF.md
# Configurable down-counting timer channel

A single decrementing timer channel driven through a small register port. The counter is 32 bits wide. It can count in a 16-bit view, where only the low half moves and the upper half is held. It can also count at the full 32-bit width. Software can switch between the two views at any time and the count is kept. A prescaler turns an external tick-enable into counting steps at a ratio of 1, 16 or 256.

Three counting behaviours are available. In periodic mode the counter reloads from a stored reload value. In free-running mode it wraps to all ones at the active width. One-shot mode can be combined with either of them, and it halts the channel once the count has reached zero. The reload value can be written in two ways. An immediate write also replaces the count. A background write changes only the reload value.

A decrement to zero sets a sticky raw interrupt, which stays set until software clears it. The interrupt output is that raw flag gated by an enable bit. The channel is meant to be placed behind a bus decoder that presents select, write enable, a register index and write data, and that takes combinational read data back.

Top module: `tmr_chan`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable only), the reload value reads 0, the count reads 0xFFFFFFFF, the raw flag reads 0 and irq_o is low. The channel is stopped, free-running and in the 16-bit view.
- R2: The control register is at index 0. Its bits are: bit0 one-shot, bit1 wide (1 = 32-bit view), bits3:2 prescale code, bit5 interrupt enable, bit6 periodic (1) or free-running (0), bit7 run. Bit 4 and bits 31:8 are not stored and read as zero.
- R3: When running, a count step occurs on every tick_i for prescale code 0, on every 16th tick_i for code 1, and on every 256th tick_i for codes 2 and 3. A control write that changes the code or clears run restarts the prescaler. After such a write, the first step comes a full divided period of ticks later.
- R4: A write to index 1 (immediate load) sets both the reload value and the whole 32-bit count. It takes priority over a step in the same cycle, and that step is then dropped.
- R5: A write to index 2 (background load) sets only the reload value. The count keeps its value or steps as usual.
- R6: In periodic mode, a step taken while the active count is zero loads the reload value. In the 16-bit view only its low half is loaded.
- R7: In free-running mode, a step taken at zero wraps the active count to 0xFFFF (16-bit view) or 0xFFFFFFFF (wide view). The reload value is not used.
- R8: A step that takes the active count from 1 to 0 sets the raw flag (read at index 4). The flag stays set until a write to index 6 clears it.
- R9: In the 16-bit view only bits 15:0 step and bits 31:16 are held. The count read (index 3) returns all 32 bits, and switching the view keeps the count.
- R10: While run is clear, no step occurs and the count changes only through an immediate load.
- R11: When a clear write and a decrement to zero fall in the same cycle, the raw flag ends up set.
- R12: In one-shot mode the count halts once it has reached zero. A control write with run set, or an immediate load, lifts the halt. The next step from zero then reloads or wraps as the mode dictates.
- R13: irq_o and the masked flag at index 5 equal the raw flag ANDed with the interrupt enable bit.
- R14: Reads of index 1 and index 2 both return the reload value. Reads of index 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 3 | Register index |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data, combinational, zero when not reading |
| tick_i | input | 1 | Counting clock enable fed to the prescaler |
| irq_o | output | 1 | Masked interrupt |

## Verification
Directed sequences come first. A 16-bit free-running count starting at 1 tells the wrap-to-0xFFFF path apart from a reload, and shows that the upper half is held across both the wrap and a switch to the wide view. A short periodic reload, a halted one-shot followed by its restart, the prescale codes 1 and 3 sampled one tick before and one tick at the divided boundary, and a clear write that lands on a decrement to zero separate the mode, ratio and priority rules. A long phase of seeded random register traffic with an irregular tick then compares every read and every cycle of irq_o against a bench model built from the requirements. This phase exercises same-cycle collisions between loads, control changes and steps, which the directed cases do not reach.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL     = 3'd0,
    REG_LOAD_NOW = 3'd1,
    REG_LOAD_BG  = 3'd2,
    REG_COUNT    = 3'd3,
    REG_RAW      = 3'd4,
    REG_MASKED   = 3'd5,
    REG_CLEAR    = 3'd6
  } reg_e;

  localparam int CTRL_W      = 8;
  localparam int CB_ONESHOT  = 0;
  localparam int CB_WIDE     = 1;
  localparam int CB_PRE_LO   = 2;
  localparam int CB_INTEN    = 5;
  localparam int CB_PERIODIC = 6;
  localparam int CB_RUN      = 7;

  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hEF;
  localparam logic [CTRL_W-1:0] CTRL_RST  = 8'h20;

  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       inten;
    logic [1:0] pre;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  function automatic ctrl_t ctrl_dec(logic [CTRL_W-1:0] r);
    ctrl_t c;
    c.run      = r[CB_RUN];
    c.periodic = r[CB_PERIODIC];
    c.inten    = r[CB_INTEN];
    c.pre      = r[CB_PRE_LO+1:CB_PRE_LO];
    c.wide     = r[CB_WIDE];
    c.oneshot  = r[CB_ONESHOT];
    return c;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int MID_LOG = 4,
  parameter int MAX_LOG = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] code_i,
  output logic       step_o
);
  localparam logic [MAX_LOG-1:0] LAST_ONE = '0;
  localparam logic [MAX_LOG-1:0] LAST_MID = MAX_LOG'((1 << MID_LOG) - 1);
  localparam logic [MAX_LOG-1:0] LAST_MAX = '1;

  logic [MAX_LOG-1:0] cnt_q, last;
  logic               wrap;

  always_comb begin
    case (code_i)
      2'd0:    last = LAST_ONE;
      2'd1:    last = LAST_MID;
      default: last = LAST_MAX;  // code 3 aliases the largest ratio
    endcase
  end

  assign wrap   = (cnt_q == last);
  assign step_o = en_i & tick_i & ~clr_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || clr_i)  cnt_q <= '0;
    else if (tick_i)          cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             wide_i,
  input  logic             periodic_i,
  input  logic             oneshot_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_hit_o,
  output logic             halted_o
);
  localparam int HW = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [HW-1:0]    lo;
  logic             halt_q, halt_d;
  logic             at_zero, at_one, adv;

  assign lo      = cnt_q[HW-1:0];
  assign at_zero = wide_i ? (cnt_q == '0) : (lo == '0);
  assign at_one  = wide_i ? (cnt_q == CNT_W'(1)) : (lo == HW'(1));
  assign adv     = step_i & ~halt_q & ~ld_i;
  assign zero_hit_o = adv & at_one;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (adv) begin
      if (at_zero) begin
        if (wide_i) cnt_d = periodic_i ? reload_i : '1;
        else        cnt_d[HW-1:0] = periodic_i ? reload_i[HW-1:0] : '1;
      end else if (wide_i) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        cnt_d[HW-1:0] = lo - 1'b1;
      end
    end
  end

  always_comb begin
    halt_d = halt_q;
    if (ld_i || restart_i)          halt_d = 1'b0;
    else if (zero_hit_o && oneshot_i) halt_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      halt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      halt_q <= halt_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign halted_o = halt_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int MID_LOG = 4,
  parameter int MAX_LOG = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              tick_i,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_new;
  ctrl_t             cf, nf;
  logic [CNT_W-1:0]  load_q, cnt_w;
  logic              raw_q;
  logic              wr_ctrl, wr_now, wr_bg, wr_clr;
  logic              pre_clr, restart, step_w, hit_w, halt_w;

  assign wr_ctrl = sel_i & we_i & (addr_i == REG_CTRL);
  assign wr_now  = sel_i & we_i & (addr_i == REG_LOAD_NOW);
  assign wr_bg   = sel_i & we_i & (addr_i == REG_LOAD_BG);
  assign wr_clr  = sel_i & we_i & (addr_i == REG_CLEAR);

  assign ctrl_new = wdata_i[CTRL_W-1:0] & CTRL_MASK;
  assign cf       = ctrl_dec(ctrl_q);
  assign nf       = ctrl_dec(ctrl_new);
  assign pre_clr  = wr_ctrl & ((nf.pre != cf.pre) | ~nf.run);
  assign restart  = wr_ctrl & nf.run;

  tmr_prescale #(.MID_LOG(MID_LOG), .MAX_LOG(MAX_LOG)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cf.run),
    .clr_i  (pre_clr),
    .tick_i (tick_i),
    .code_i (cf.pre),
    .step_o (step_w)
  );

  tmr_count_core #(.CNT_W(CNT_W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step_w),
    .wide_i     (cf.wide),
    .periodic_i (cf.periodic),
    .oneshot_i  (cf.oneshot),
    .reload_i   (load_q),
    .ld_i       (wr_now),
    .ld_val_i   (wdata_i),
    .restart_i  (restart),
    .cnt_o      (cnt_w),
    .zero_hit_o (hit_w),
    .halted_o   (halt_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      load_q <= '0;
      raw_q  <= 1'b0;
    end else begin
      if (wr_ctrl)         ctrl_q <= ctrl_new;
      if (wr_now || wr_bg) load_q <= wdata_i;
      if (hit_w)           raw_q  <= 1'b1;  // set beats clear
      else if (wr_clr)     raw_q  <= 1'b0;
    end
  end

  assign irq_o = raw_q & cf.inten;

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      case (addr_i)
        REG_CTRL:                 rdata_o = CNT_W'(ctrl_q);
        REG_LOAD_NOW, REG_LOAD_BG: rdata_o = load_q;
        REG_COUNT:                rdata_o = cnt_w;
        REG_RAW:                  rdata_o = CNT_W'(raw_q);
        REG_MASKED:               rdata_o = CNT_W'(irq_o);
        default:                  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic              step_i,
  input logic              hit_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              raw_i,
  input logic              run_i,
  input logic              wide_i,
  input logic              halt_i
);
  localparam int HW = CNT_W / 2;

  logic wr_now, wr_bg, wr_clr;
  assign wr_now = sel_i & we_i & (addr_i == REG_LOAD_NOW);
  assign wr_bg  = sel_i & we_i & (addr_i == REG_LOAD_BG);
  assign wr_clr = sel_i & we_i & (addr_i == REG_CLEAR);

  assert_load_sets_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_now |=> (cnt_i == $past(wdata_i)));

  assert_bg_keeps_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_bg && !step_i) |=> $stable(cnt_i));

  assert_upper_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && !wr_now) |=> $stable(cnt_i[CNT_W-1:HW]));

  assert_raw_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_i) |-> $past(hit_i));

  assert_clear_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && !hit_i) |=> !raw_i);

  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> raw_i);

  assert_frozen_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_now) |=> $stable(cnt_i));

  assert_oneshot_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !wr_now) |=> $stable(cnt_i));
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .step_i  (step_w),
  .hit_i   (hit_w),
  .cnt_i   (cnt_w),
  .raw_i   (raw_q),
  .run_i   (cf.run),
  .wide_i  (cf.wide),
  .halt_i  (halt_w)
);

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module test_tmr_chan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, we_i = 1'b0, tick_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit tick_lv = 1'b1;

  tmr_chan i_tmr_chan (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i), .irq_o(irq_o)
  );

  always #10 clk_i = ~clk_i;

  // requirement-level model
  logic [7:0]  m_ctrl;
  logic [31:0] m_load, m_cnt, m_nv, m_lowv;
  bit          m_raw, m_halt, m_step, m_hit, m_pclr, m_ldw, m_wr;
  int unsigned m_pre, m_last;
  logic [7:0]  m_newc;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_ctrl = 8'h20; m_load = 32'h0; m_cnt = 32'hFFFF_FFFF;
      m_raw = 1'b0; m_halt = 1'b0; m_pre = 0;
    end else begin
      m_wr   = sel_i && we_i;
      m_newc = wdata_i[7:0] & 8'hEF;
      m_pclr = m_wr && addr_i == 3'd0 && (m_newc[3:2] != m_ctrl[3:2] || !m_newc[7]);
      m_last = (m_ctrl[3:2] == 2'd0) ? 0 : (m_ctrl[3:2] == 2'd1) ? 15 : 255;
      m_step = m_ctrl[7] && tick_i && !m_pclr && m_pre == m_last;
      if (!m_ctrl[7] || m_pclr) m_pre = 0;
      else if (tick_i) m_pre = (m_pre == m_last) ? 0 : m_pre + 1;
      m_ldw = m_wr && addr_i == 3'd1;
      m_hit = 1'b0;
      if (m_ldw) m_cnt = wdata_i;
      else if (m_step && !m_halt) begin
        m_lowv = m_ctrl[1] ? m_cnt : {16'h0, m_cnt[15:0]};
        if (m_lowv == 32'h0)
          m_nv = m_ctrl[6] ? (m_ctrl[1] ? m_load : {16'h0, m_load[15:0]})
                           : (m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF);
        else begin
          m_nv  = m_lowv - 32'd1;
          m_hit = (m_lowv == 32'd1);
        end
        m_cnt = m_ctrl[1] ? m_nv : {m_cnt[31:16], m_nv[15:0]};
      end
      if (m_ldw || (m_wr && addr_i == 3'd0 && m_newc[7])) m_halt = 1'b0;
      else if (m_hit && m_ctrl[0]) m_halt = 1'b1;
      if (m_hit) m_raw = 1'b1;
      else if (m_wr && addr_i == 3'd6) m_raw = 1'b0;
      if (m_wr && (addr_i == 3'd1 || addr_i == 3'd2)) m_load = wdata_i;
      if (m_wr && addr_i == 3'd0) m_ctrl = m_newc;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0:       return {24'h0, m_ctrl};
      3'd1, 3'd2: return m_load;
      3'd3:       return m_cnt;
      3'd4:       return {31'h0, m_raw};
      3'd5:       return {31'h0, m_raw & m_ctrl[5]};
      default:    return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0:       return "R2";
      3'd1, 3'd2: return "R5";
      3'd3:       return "R6";
      3'd4:       return "R8";
      3'd5:       return "R13";
      default:    return "R14";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive, check against model, pass one rising edge
  task automatic drive(input bit s, input bit w, input logic [2:0] a, input logic [31:0] d);
    sel_i = s; we_i = w; addr_i = a; wdata_i = d; tick_i = tick_lv;
    #1;
    check("R13", {31'h0, irq_o}, {31'h0, m_raw & m_ctrl[5]});
    if (s && !w) check(tag_of(a), rdata_o, exp_rd(a));
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    drive(1'b1, 1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 3'd0, 32'h0);
  endtask

  // read without advancing time past the next edge
  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    sel_i = 1'b1; we_i = 1'b0; addr_i = a; tick_i = tick_lv;
    #1;
    check(tag, rdata_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd_chk(3'd0, 32'h20, "R1");
    rd_chk(3'd3, 32'hFFFF_FFFF, "R1");
    rd_chk(3'd1, 32'h0, "R1");
    rd_chk(3'd4, 32'h0, "R1");
    check("R1", {31'h0, irq_o}, 32'h0);
    rd_chk(3'd7, 32'h0, "R14");

    // R2 unused control bits are dropped
    wr(3'd0, 32'h7F10);
    rd_chk(3'd0, 32'h0, "R2");
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk(3'd0, 32'hEF, "R2");
    wr(3'd0, 32'h20);

    // R4/R7/R9 16-bit free-running wrap keeps the upper half
    wr(3'd1, 32'h1234_0001);
    rd_chk(3'd3, 32'h1234_0001, "R4");
    wr(3'd0, 32'hA0);
    idle(1);
    rd_chk(3'd3, 32'h1234_0000, "R9");
    rd_chk(3'd4, 32'h1, "R8");
    idle(1);
    rd_chk(3'd3, 32'h1234_FFFF, "R7");
    idle(1);
    wr(3'd0, 32'hA2);
    rd_chk(3'd3, 32'h1234_FFFD, "R9");
    idle(1);
    rd_chk(3'd3, 32'h1234_FFFC, "R9");
    wr(3'd2, 32'h5);
    rd_chk(3'd3, 32'h1234_FFFB, "R5");
    rd_chk(3'd1, 32'h5, "R14");

    // R6 periodic 16-bit reload
    wr(3'd0, 32'h0);
    wr(3'd1, 32'hABCD_0002);
    wr(3'd0, 32'hE0);
    idle(1);
    rd_chk(3'd3, 32'hABCD_0001, "R6");
    idle(1);
    rd_chk(3'd3, 32'hABCD_0000, "R6");
    idle(1);
    rd_chk(3'd3, 32'hABCD_0002, "R6");

    // R12 one-shot halt and restart
    wr(3'd0, 32'h0);
    wr(3'd6, 32'h0);
    wr(3'd1, 32'h2);
    wr(3'd0, 32'hE3);
    idle(2);
    rd_chk(3'd3, 32'h0, "R12");
    idle(5);
    rd_chk(3'd3, 32'h0, "R12");
    rd_chk(3'd4, 32'h1, "R12");
    wr(3'd0, 32'hE3);
    rd_chk(3'd3, 32'h0, "R12");
    idle(1);
    rd_chk(3'd3, 32'h2, "R12");
    idle(1);
    rd_chk(3'd3, 32'h1, "R12");

    // R3 divide by 16
    wr(3'd0, 32'h0);
    wr(3'd1, 32'd100);
    wr(3'd0, 32'h86);
    idle(15);
    rd_chk(3'd3, 32'd100, "R3");
    idle(1);
    rd_chk(3'd3, 32'd99, "R3");

    // R3 code 3 behaves as divide by 256
    wr(3'd0, 32'h0);
    wr(3'd1, 32'd1000);
    wr(3'd0, 32'h8E);
    idle(255);
    rd_chk(3'd3, 32'd1000, "R3");
    idle(1);
    rd_chk(3'd3, 32'd999, "R3");

    // R10 disabled count is frozen
    wr(3'd0, 32'h22);
    idle(20);
    rd_chk(3'd3, 32'd999, "R10");

    // R11 set beats clear
    wr(3'd0, 32'h0);
    wr(3'd6, 32'h0);
    wr(3'd1, 32'h1);
    wr(3'd0, 32'hE2);
    wr(3'd6, 32'h0);
    rd_chk(3'd4, 32'h1, "R11");
    wr(3'd6, 32'h0);
    rd_chk(3'd4, 32'h0, "R8");
    wr(3'd6, 32'h0);
    rd_chk(3'd4, 32'h1, "R11");

    // R13 mask
    wr(3'd0, 32'h02);
    rd_chk(3'd5, 32'h0, "R13");
    rd_chk(3'd4, 32'h1, "R13");
    check("R13", {31'h0, irq_o}, 32'h0);
    wr(3'd0, 32'h22);
    rd_chk(3'd5, 32'h1, "R13");

    // random traffic against the model
    for (int k = 0; k < 20000; k++) begin
      int unsigned r;
      logic [31:0] d;
      r = $urandom % 100;
      tick_lv = ($urandom % 4) != 0;
      d = $urandom;
      if (r < 5) begin
        if ($urandom % 4 != 0) d[3:2] = 2'd0;
        if ($urandom % 3 != 0) d[7] = 1'b1;
        wr(3'd0, d);
      end else if (r < 10) begin
        if ($urandom % 4 != 0) d = $urandom % 40;
        wr(3'd1, d);
      end else if (r < 13) begin
        if ($urandom % 2 != 0) d = $urandom % 40;
        wr(3'd2, d);
      end else if (r < 18) begin
        wr(3'd6, d);
      end else begin
        logic [2:0] a;
        a = 3'($urandom % 8);
        drive(1'b1, 1'b0, a, 32'h0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule